// File: doc/BRIEF.md
# External Pin Interrupt and Wake Controller

This block takes one dedicated interrupt pin and a group of six pin-change inputs and turns them into two interrupt requests, two sticky flags and a wake request for a small microcontroller core. The dedicated pin has a programmable sense field that selects low level, any edge, falling edge or rising edge. Each pin-change input contributes only when its bit in the mask is set. The block reads the pin level, not the pin direction. A pin that the chip itself drives as an output therefore still raises interrupts, and software can use this to post its own requests.

All pins pass through a two-stage synchronizer before any event is detected in the clock domain. Edge detection on the dedicated pin counts only while the I/O clock enable is high. Low-level and pin-change conditions are also formed combinationally from the raw pins, so that they can raise the wake request in a deep sleep state where the I/O clock is stopped. Interrupt requests are held back until the start-up-done input is high. If a low level wakes the part but is gone before start-up finishes, the part wakes and no interrupt is posted.

Top module: `extint_wake_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, ext_flag, pc_flag, ext_irq, pc_irq and wake are all 0.
- R2: With sense_mode 00 (low level), ext_flag stays 0, and ext_irq equals ext_en & startup_done & (synchronised ext_pin is 0). The synchronised pin lags the raw pin by two clock edges. The request stays high for as long as the pin is held low.
- R3: With sense_mode 01 (any edge), 10 (falling) or 11 (rising), a matching change of the synchronised ext_pin sets ext_flag on the third clock edge after the pin changes. This happens only if io_clk_en is 1 in that cycle. An edge seen while io_clk_en is 0 is lost and never sets the flag.
- R4: A toggle of pc_pins[i] sets pc_flag on the third clock edge after the change only when pc_mask[i] is 1. A toggle on an input whose mask bit is 0 leaves pc_flag and pc_irq unchanged.
- R5: ext_flag and pc_flag stay set until their clear strobe (ext_clr, pc_clr) is sampled. A clear in the same cycle as a new event leaves the flag set.
- R6: ext_irq equals ext_en & startup_done & ext_flag in the edge modes. pc_irq equals pc_en & startup_done & pc_flag.
- R7: wake is combinational and equals asleep & (low-level term | pin-change term | ext_en & ext_flag | pc_en & pc_flag). The low-level term is ext_en & sense_mode==00 & raw ext_pin==0. The pin-change term is pc_en & (any masked raw pc_pins bit differs from its last registered synchronised value).
- R8: If a low level raises wake but the pin returns high before startup_done rises, ext_irq stays 0 once startup_done is 1. If the pin is still low at that point, ext_irq is 1.
- R9: In a cycle where cfg_wr is 1, no edge or pin-change event is recorded, so a configuration write cannot create a spurious flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk_en | input | 1 | I/O clock running; edge detection only while 1 |
| ext_pin | input | 1 | Raw level of the dedicated interrupt pin |
| pc_pins | input | 6 | Raw levels of the pin-change inputs |
| sense_mode | input | 2 | 00 low level, 01 any edge, 10 falling, 11 rising |
| pc_mask | input | 6 | Per-input enable for pin-change detection |
| cfg_wr | input | 1 | Configuration write strobe; suppresses events that cycle |
| ext_en | input | 1 | Enable for the dedicated-pin request |
| pc_en | input | 1 | Enable for the pin-change request |
| asleep | input | 1 | Core is in a sleep state |
| startup_done | input | 1 | Clock start-up period finished |
| ext_clr | input | 1 | Clear strobe for ext_flag |
| pc_clr | input | 1 | Clear strobe for pc_flag |
| ext_irq | output | 1 | Dedicated-pin interrupt request |
| pc_irq | output | 1 | Pin-change interrupt request |
| ext_flag | output | 1 | Sticky dedicated-pin edge flag |
| pc_flag | output | 1 | Sticky pin-change flag |
| wake | output | 1 | Combinational wake request |

## Verification
The wake output responds in the same cycle as a raw pin change, so the bench checks it one nanosecond after it drives the pin. The low-level request follows the pin after two clock edges. Flags set on the third edge after a pin change, so directed checks sample one nanosecond after that edge. A behavioural model keeps a queue of sampled pin values and predicts every output from the pins seen two and three edges back. It is compared just before each rising edge, when inputs have been stable for half a period. Clear strobes and configuration writes are placed on the exact edge where the event lands, which checks the collision rules.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Edge match between the registered previous value and the current sample.
  function automatic logic edge_hit(sense_e mode, logic prev, logic cur);
    case (mode)
      SENSE_ANY:  return prev ^ cur;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/extint_ext_sense.sv
module extint_ext_sense
  import extint_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   io_clk_en,
  input  logic   cfg_wr,
  input  sense_e sense,
  input  logic   pin_s,
  input  logic   clr,
  output logic   flag,
  output logic   edge_ev,
  output logic   level_act
);
  logic prev_q;
  logic flag_q;

  assign edge_ev   = io_clk_en & ~cfg_wr & edge_hit(sense, prev_q, pin_s);
  assign level_act = (sense == SENSE_LOW) & ~pin_s;
  assign flag      = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (sense == SENSE_LOW) flag_q <= 1'b0;
      else                    flag_q <= edge_ev | (flag_q & ~clr);
    end
  end

  AST_EDGE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_clk_en && !flag_q) |=> !flag_q); // R3
  AST_EXT_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr && sense != SENSE_LOW) |=> flag_q); // R5
  AST_EXT_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_ev) |=> !flag_q); // R5
  AST_LOW_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_LOW) |=> !flag_q); // R2
endmodule

// File: rtl/extint_pc_detect.sv
module extint_pc_detect #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [WIDTH-1:0] pins_s,
  input  logic [WIDTH-1:0] pins_raw,
  input  logic [WIDTH-1:0] mask,
  input  logic             clr,
  output logic             flag,
  output logic             pc_ev,
  output logic             raw_change
);
  logic [WIDTH-1:0] prev_q;
  logic             flag_q;

  assign pc_ev      = ~cfg_wr & (|((pins_s ^ prev_q) & mask));
  assign raw_change = |((pins_raw ^ prev_q) & mask);
  assign flag       = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pins_s;
      flag_q <= pc_ev | (flag_q & ~clr);
    end
  end

  AST_PC_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !flag_q) |=> !flag_q); // R9
  AST_PC_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && !flag_q) |=> !flag_q); // R4
  AST_PC_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pc_ev) |=> !flag_q); // R5
  AST_PC_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R5
endmodule

// File: rtl/extint_wake_ctrl.sv
module extint_wake_ctrl
  import extint_pkg::*;
#(
  parameter int PC_WIDTH    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_clk_en,
  input  logic                ext_pin,
  input  logic [PC_WIDTH-1:0] pc_pins,
  input  logic [1:0]          sense_mode,
  input  logic [PC_WIDTH-1:0] pc_mask,
  input  logic                cfg_wr,
  input  logic                ext_en,
  input  logic                pc_en,
  input  logic                asleep,
  input  logic                startup_done,
  input  logic                ext_clr,
  input  logic                pc_clr,
  output logic                ext_irq,
  output logic                pc_irq,
  output logic                ext_flag,
  output logic                pc_flag,
  output logic                wake
);
  localparam int SyncW = PC_WIDTH + 1;

  sense_e            sense;
  logic [SyncW-1:0]  pins_s;
  logic              ext_s;
  logic [PC_WIDTH-1:0] pc_s;
  logic              ext_edge_ev;
  logic              ext_level_act;
  logic              pc_ev;
  logic              pc_raw_change;
  logic              wake_level;
  logic              wake_pc;
  logic              wake_flags;

  assign sense = sense_e'(sense_mode);

  extint_sync #(.WIDTH(SyncW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({pc_pins, ext_pin}),
    .dout (pins_s)
  );

  assign ext_s = pins_s[0];
  assign pc_s  = pins_s[SyncW-1:1];

  extint_ext_sense u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_clk_en(io_clk_en),
    .cfg_wr   (cfg_wr),
    .sense    (sense),
    .pin_s    (ext_s),
    .clr      (ext_clr),
    .flag     (ext_flag),
    .edge_ev  (ext_edge_ev),
    .level_act(ext_level_act)
  );

  extint_pc_detect #(.WIDTH(PC_WIDTH)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .pins_s    (pc_s),
    .pins_raw  (pc_pins),
    .mask      (pc_mask),
    .clr       (pc_clr),
    .flag      (pc_flag),
    .pc_ev     (pc_ev),
    .raw_change(pc_raw_change)
  );

  // Requests wait for the start-up period to finish.
  always_comb begin
    if (sense == SENSE_LOW) ext_irq = ext_en & startup_done & ext_level_act;
    else                    ext_irq = ext_en & startup_done & ext_flag;
    pc_irq = pc_en & startup_done & pc_flag;
  end

  // Raw-pin terms keep working with the I/O clock halted.
  assign wake_level = ext_en & (sense == SENSE_LOW) & ~ext_pin;
  assign wake_pc    = pc_en & pc_raw_change;
  assign wake_flags = (ext_en & ext_flag) | (pc_en & pc_flag);
  assign wake       = asleep & (wake_level | wake_pc | wake_flags);

  AST_IRQ_WAITS_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!startup_done && !ext_level_act) |-> !ext_irq || sense != SENSE_LOW); // R8
  AST_PC_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ev |=> pc_flag); // R4
endmodule

// File: tb/test_extint_wake_ctrl.sv
module test_extint_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_clk_en = 1'b1, ext_pin = 1'b0, cfg_wr = 1'b0;
  logic [5:0] pc_pins = '0, pc_mask = '0;
  logic [1:0] sense_mode = 2'b10;
  logic       ext_en = 1'b0, pc_en = 1'b0, asleep = 1'b0, startup_done = 1'b1;
  logic       ext_clr = 1'b0, pc_clr = 1'b0;
  logic       ext_irq, pc_irq, ext_flag, pc_flag, wake;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  extint_wake_ctrl i_extint_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .ext_pin(ext_pin),
    .pc_pins(pc_pins), .sense_mode(sense_mode), .pc_mask(pc_mask),
    .cfg_wr(cfg_wr), .ext_en(ext_en), .pc_en(pc_en), .asleep(asleep),
    .startup_done(startup_done), .ext_clr(ext_clr), .pc_clr(pc_clr),
    .ext_irq(ext_irq), .pc_irq(pc_irq), .ext_flag(ext_flag),
    .pc_flag(pc_flag), .wake(wake)
  );

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // Reference model: history of pin samples, newest first.
  logic [6:0] hist[$];
  logic       m_ext_flag, m_pc_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{7'd0, 7'd0, 7'd0};
      m_ext_flag = 1'b0;
      m_pc_flag  = 1'b0;
    end else begin
      logic cur, old, ev;
      logic [5:0] ch;
      cur = hist[1][0];
      old = hist[2][0];
      case (sense_mode)
        2'b01:   ev = cur != old;
        2'b10:   ev = old && !cur;
        2'b11:   ev = !old && cur;
        default: ev = 1'b0;
      endcase
      ev = ev && io_clk_en && !cfg_wr;
      m_ext_flag = (sense_mode == 2'b00) ? 1'b0 : (ev || (m_ext_flag && !ext_clr));
      ch = (hist[1][6:1] ^ hist[2][6:1]) & pc_mask;
      m_pc_flag = ((ch != 0) && !cfg_wr) || (m_pc_flag && !pc_clr);
      hist.push_front({pc_pins, ext_pin});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    #4;
    if (rst_n && !done) begin
      logic e_irq, p_irq, e_wake;
      e_irq = ext_en && startup_done &&
              ((sense_mode == 2'b00) ? !hist[1][0] : m_ext_flag);
      p_irq = pc_en && startup_done && m_pc_flag;
      e_wake = asleep && ((ext_en && sense_mode == 2'b00 && !ext_pin) ||
               (pc_en && (((pc_pins ^ hist[2][6:1]) & pc_mask) != 0)) ||
               (ext_en && m_ext_flag) || (pc_en && m_pc_flag));
      chk("R3 model ext_flag", ext_flag, m_ext_flag);
      chk("R4 model pc_flag", pc_flag, m_pc_flag);
      chk("R6 model ext_irq", ext_irq, e_irq);
      chk("R6 model pc_irq", pc_irq, p_irq);
      chk("R7 model wake", wake, e_wake);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2;
    chk("R1 reset ext_flag", ext_flag, 1'b0);
    chk("R1 reset pc_flag", pc_flag, 1'b0);
    chk("R1 reset wake", wake, 1'b0);
    step(3);
    @(negedge clk) rst_n = 1'b1;
    step(1);
    chk("R1 after reset ext_irq", ext_irq, 1'b0);
    chk("R1 after reset pc_irq", pc_irq, 1'b0);

    // R2: low-level mode follows the synchronised pin.
    @(negedge clk); sense_mode = 2'b00; ext_en = 1'b1; ext_pin = 1'b1;
    step(4);
    @(negedge clk) ext_pin = 1'b0;
    step(2);
    chk("R2 level irq after two edges", ext_irq, 1'b1);
    step(5);
    chk("R2 level irq held", ext_irq, 1'b1);
    chk("R2 no flag in level mode", ext_flag, 1'b0);
    @(negedge clk) ext_pin = 1'b1;
    step(2);
    chk("R2 level irq released", ext_irq, 1'b0);

    // R3: falling edge sets the flag on the third edge.
    @(negedge clk) sense_mode = 2'b10;
    step(3);
    @(negedge clk) ext_pin = 1'b0;
    step(2);
    chk("R3 flag not yet", ext_flag, 1'b0);
    step(1);
    chk("R3 falling sets flag", ext_flag, 1'b1);
    chk("R6 ext_irq from flag", ext_irq, 1'b1);

    // R5: clear colliding with a new event keeps the flag.
    @(negedge clk) ext_pin = 1'b1;
    step(3);
    @(negedge clk) ext_pin = 1'b0;
    step(2);
    @(negedge clk) ext_clr = 1'b1;
    step(1);
    chk("R5 clear with event keeps flag", ext_flag, 1'b1);
    step(1);
    chk("R5 clear alone drops flag", ext_flag, 1'b0);
    @(negedge clk) ext_clr = 1'b0;

    // R3: rising and any-edge modes; lost edges with the clock off.
    @(negedge clk) sense_mode = 2'b11; io_clk_en = 1'b0; ext_pin = 1'b1;
    step(5);
    @(negedge clk) io_clk_en = 1'b1;
    step(4);
    chk("R3 edge lost with io clock off", ext_flag, 1'b0);
    @(negedge clk) sense_mode = 2'b01; ext_pin = 1'b0;
    step(3);
    chk("R3 any edge sets flag", ext_flag, 1'b1);
    @(negedge clk) ext_clr = 1'b1;
    @(negedge clk) ext_clr = 1'b0;

    // R9: configuration write on the event cycle suppresses it.
    @(negedge clk) ext_pin = 1'b1;
    step(2);
    @(negedge clk) cfg_wr = 1'b1;
    step(1);
    @(negedge clk) cfg_wr = 1'b0;
    step(3);
    chk("R9 cfg write drops ext event", ext_flag, 1'b0);

    // R4: pin-change masking.
    @(negedge clk) pc_en = 1'b1; pc_mask = 6'b000100; pc_pins[2] = 1'b1;
    step(3);
    chk("R4 masked-in toggle sets flag", pc_flag, 1'b1);
    chk("R6 pc_irq from flag", pc_irq, 1'b1);
    @(negedge clk) pc_clr = 1'b1;
    @(negedge clk) pc_clr = 1'b0; pc_pins[0] = 1'b1;
    step(4);
    chk("R4 masked-out toggle ignored", pc_flag, 1'b0);
    chk("R4 masked-out no irq", pc_irq, 1'b0);

    // R9 on the pin-change path.
    @(negedge clk) pc_pins[2] = 1'b0;
    step(2);
    @(negedge clk) cfg_wr = 1'b1; pc_mask = 6'b000110;
    step(1);
    @(negedge clk) cfg_wr = 1'b0;
    step(3);
    chk("R9 cfg write drops pc event", pc_flag, 1'b0);

    // R7: pin-change wake with the clock stopped.
    @(negedge clk) ext_en = 1'b0; asleep = 1'b1; io_clk_en = 1'b0;
    startup_done = 1'b0;
    @(negedge clk) pc_pins[1] = 1'b1;
    #1 chk("R7 raw pin change wakes at once", wake, 1'b1);
    step(4);
    @(negedge clk) pc_clr = 1'b1;
    @(negedge clk) pc_clr = 1'b0; pc_en = 1'b0;
    #1 chk("R7 no wake when idle", wake, 1'b0);

    // R8: level removed during start-up.
    @(negedge clk) sense_mode = 2'b00; ext_en = 1'b1;
    @(negedge clk) ext_pin = 1'b0;
    #1 chk("R7 low level wakes at once", wake, 1'b1);
    chk("R8 no irq before start-up", ext_irq, 1'b0);
    step(3);
    @(negedge clk) ext_pin = 1'b1;
    step(3);
    @(negedge clk) asleep = 1'b0; startup_done = 1'b1; io_clk_en = 1'b1;
    #1 chk("R8 vanished level posts no irq", ext_irq, 1'b0);
    @(negedge clk) asleep = 1'b1; startup_done = 1'b0; io_clk_en = 1'b0;
    @(negedge clk) ext_pin = 1'b0;
    step(3);
    @(negedge clk) asleep = 1'b0; startup_done = 1'b1; io_clk_en = 1'b1;
    #1 chk("R8 held level posts irq", ext_irq, 1'b1);
    step(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule